// File: doc/BRIEF.md
# Sampled XOR Phase Meter

This block measures the phase difference between a reference square wave and a feedback square wave, as the phase-comparison stage of a digital phase-locked loop. A fast system clock samples both waves. Each wave passes through its own two-flop synchronizer, and the two synchronized levels are combined by exclusive-OR.

Between two consecutive rising edges of the synchronized reference, the block counts two things: the clock cycles in which the exclusive-OR is high, and all clock cycles. At each reference rising edge it presents both counts, together with a one-cycle valid strobe. The ratio of the two counts is the phase magnitude as a fraction of half a turn. Zero means the waves are in phase. Half the period means a quarter turn, which is the usual lock point. The full period means the waves are in antiphase. A lead and an equal lag give the same count, because the measurement has no sign. The loop controller that reads the result must lock at the quarter-turn point for this reason.

Both counters stop at their largest value instead of wrapping. When either counter reaches that stop, a sticky overflow flag is raised. Reset is synchronous and active high.

Top module: `xor_phase_meter`

## Requirements
- R1: Each input reaches the measurement logic through two flops. When `ref_i` is first sampled high at a clock edge and the block is already measuring, `valid_o` rises on the third rising clock edge counted from that edge.
- R2: Two inputs with identical waveforms give `hi_cnt_o` = 0.
- R3: `hi_cnt_o` equals the number of sampled cycles in the period in which the two synchronized inputs differed. For 50% duty waves offset by d cycles (|d| ≤ half the period), this is 2·|d|. It never exceeds `per_cnt_o`.
- R4: Antiphase inputs (offset of half the period) give `hi_cnt_o` equal to `per_cnt_o`.
- R5: `per_cnt_o` equals the number of clock cycles between two consecutive synchronized reference rising edges. Both result outputs hold their values while `valid_o` is low.
- R6: A feedback lead of d cycles and a lag of d cycles give the same `hi_cnt_o`.
- R7: A quarter-period offset gives `hi_cnt_o` equal to half of `per_cnt_o`.
- R8: The first reference rising edge after reset only starts a measurement. Over n reference periods starting from reset, `valid_o` pulses n−1 times.
- R9: `valid_o` is high for exactly one clock cycle per reference rising edge.
- R10: Both counts saturate at 2^CNT_W−1. When a count is held at that value, `ovf_o` is set and stays set until reset.
- R11: While `rst` is high at a clock edge, `valid_o`, `hi_cnt_o`, `per_cnt_o` and `ovf_o` are cleared to 0 and the measurement is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_i | input | 1 | Reference square wave, asynchronous |
| fb_i | input | 1 | Feedback square wave, asynchronous |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| hi_cnt_o | output | CNT_W | Cycles with differing inputs in the last period |
| per_cnt_o | output | CNT_W | Length of the last reference period in cycles |
| ovf_o | output | 1 | Sticky saturation flag |

## Verification
The assertions assume that every reference period lasts at least two clock cycles after synchronization, so two result strobes can never fall on neighbouring cycles. The stimulus keeps to this: every reference high and low phase is driven for at least ten clock cycles, and the inputs change only on the falling clock edge. The saturation property takes the counter width as given. The bench therefore builds the block with an 8-bit width, so that a period of a few hundred cycles can reach saturation.

// File: rtl/xpd_pkg.sv
package xpd_pkg;

    localparam int DEFAULT_CNT_W = 16;
    localparam int SYNC_STAGES   = 2;
    localparam int N_CHAN        = 2;
    localparam int CH_REF        = 0;
    localparam int CH_FB         = 1;

    typedef enum logic {
        MEAS_IDLE = 1'b0,
        MEAS_RUN  = 1'b1
    } meas_state_e;

    typedef struct packed {
        logic ref_lvl;
        logic ref_prev;
        logic fb_lvl;
    } sample_t;

    function automatic logic rising(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

    function automatic logic differ(input logic a, input logic b);
        return a ^ b;
    endfunction

endpackage

// File: rtl/xpd_sync.sv
module xpd_sync #(
    parameter int STAGES = xpd_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/xpd_integrator.sv
module xpd_integrator #(
    parameter int CNT_W = xpd_pkg::DEFAULT_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise_i,
    input  logic             xor_i,
    output logic             valid_o,
    output logic [CNT_W-1:0] hi_o,
    output logic [CNT_W-1:0] per_o,
    output logic             ovf_o
);
    import xpd_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    meas_state_e      state_q;
    logic [CNT_W-1:0] acc_hi_q;
    logic [CNT_W-1:0] acc_per_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= MEAS_IDLE;
            acc_hi_q  <= '0;
            acc_per_q <= '0;
            valid_o   <= 1'b0;
            hi_o      <= '0;
            per_o     <= '0;
            ovf_o     <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (rise_i) begin
                if (state_q == MEAS_RUN) begin
                    valid_o <= 1'b1;
                    hi_o    <= acc_hi_q;
                    per_o   <= acc_per_q;
                end
                state_q   <= MEAS_RUN;
                acc_hi_q  <= CNT_W'(xor_i);
                acc_per_q <= CNT_W'(1);
            end else if (state_q == MEAS_RUN) begin
                if (acc_per_q == CNT_MAX) begin
                    ovf_o <= 1'b1;
                end else begin
                    acc_per_q <= acc_per_q + 1'b1;
                end
                if (xor_i) begin
                    if (acc_hi_q == CNT_MAX) begin
                        ovf_o <= 1'b1;
                    end else begin
                        acc_hi_q <= acc_hi_q + 1'b1;
                    end
                end
            end
        end
    end

    // R3: high count can never run ahead of the period count
    a_r3_hi_within_period: assert property (@(posedge clk) disable iff (rst)
        acc_hi_q <= acc_per_q);

    // R9: a strobe lasts one cycle (periods are at least two cycles long)
    a_r9_single_cycle_valid: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R10: overflow flag is sticky
    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> ovf_o);

    // R5: results hold between strobes
    a_r5_result_hold: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(hi_o) && $stable(per_o)));

    // R8: a strobe only follows a rise seen while a measurement was running
    a_r8_no_valid_unarmed: assert property (@(posedge clk) disable iff (rst)
        (rise_i && state_q == MEAS_IDLE) |=> !valid_o);
endmodule

// File: rtl/xor_phase_meter.sv
module xor_phase_meter #(
    parameter int CNT_W = xpd_pkg::DEFAULT_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_i,
    input  logic             fb_i,
    output logic             valid_o,
    output logic [CNT_W-1:0] hi_cnt_o,
    output logic [CNT_W-1:0] per_cnt_o,
    output logic             ovf_o
);
    import xpd_pkg::*;

    logic [N_CHAN-1:0] raw_in;
    logic [N_CHAN-1:0] sync_lvl;
    sample_t           smp;
    logic              ref_prev_q;

    assign raw_in[CH_REF] = ref_i;
    assign raw_in[CH_FB]  = fb_i;

    for (genvar ch = 0; ch < N_CHAN; ch++) begin : g_sync
        xpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst    (rst),
            .async_i(raw_in[ch]),
            .sync_o (sync_lvl[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) ref_prev_q <= 1'b0;
        else     ref_prev_q <= sync_lvl[CH_REF];
    end

    always_comb begin
        smp.ref_lvl  = sync_lvl[CH_REF];
        smp.ref_prev = ref_prev_q;
        smp.fb_lvl   = sync_lvl[CH_FB];
    end

    xpd_integrator #(.CNT_W(CNT_W)) u_int (
        .clk    (clk),
        .rst    (rst),
        .rise_i (rising(smp.ref_lvl, smp.ref_prev)),
        .xor_i  (differ(smp.ref_lvl, smp.fb_lvl)),
        .valid_o(valid_o),
        .hi_o   (hi_cnt_o),
        .per_o  (per_cnt_o),
        .ovf_o  (ovf_o)
    );

    // R11: reset leaves every output cleared on the next cycle
    a_r11_reset_clears: assert property (@(posedge clk)
        rst |=> (!valid_o && !ovf_o && hi_cnt_o == '0 && per_cnt_o == '0));
endmodule

// File: tb/sim_xor_phase_meter.sv
module sim_xor_phase_meter;

    localparam int W   = 8;
    localparam int MAX = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ref_i = 1'b0;
    logic         fb_i = 1'b0;
    logic         valid_o;
    logic [W-1:0] hi_cnt_o;
    logic [W-1:0] per_cnt_o;
    logic         ovf_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    xor_phase_meter #(.CNT_W(W)) u0 (
        .clk(clk), .rst(rst), .ref_i(ref_i), .fb_i(fb_i),
        .valid_o(valid_o), .hi_cnt_o(hi_cnt_o), .per_cnt_o(per_cnt_o), .ovf_o(ovf_o)
    );

    always #5 clk = ~clk;

    // behavioural reference model: sample queues plus integer counters
    bit ref_q[$] = '{0, 0, 0};
    bit fb_q[$]  = '{0, 0, 0};
    bit m_armed = 0;
    int m_hi_acc = 0, m_per_acc = 0;
    bit m_valid = 0, m_ovf = 0;
    int m_hi = 0, m_per = 0;

    always @(posedge clk) begin
        if (rst) begin
            ref_q = '{0, 0, 0};
            fb_q  = '{0, 0, 0};
            m_armed = 0; m_hi_acc = 0; m_per_acc = 0;
            m_valid = 0; m_ovf = 0; m_hi = 0; m_per = 0;
        end else begin
            bit lvl, prev, x;
            lvl  = ref_q[1];
            prev = ref_q[2];
            x    = lvl != fb_q[1];
            m_valid = 0;
            if (lvl && !prev) begin
                if (m_armed) begin
                    m_valid = 1; m_hi = m_hi_acc; m_per = m_per_acc;
                end
                m_armed = 1; m_hi_acc = x ? 1 : 0; m_per_acc = 1;
            end else if (m_armed) begin
                if (m_per_acc >= MAX) m_ovf = 1; else m_per_acc++;
                if (x) begin
                    if (m_hi_acc >= MAX) m_ovf = 1; else m_hi_acc++;
                end
            end
            void'(ref_q.pop_back()); ref_q.push_front(ref_i);
            void'(fb_q.pop_back());  fb_q.push_front(fb_i);
        end
    end

    task automatic check(string req, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // per-clock comparison against the model (R1 timing, R9, R10, R11 throughout)
    bit cmp_en = 0;
    always @(negedge clk) begin
        cyc++;
        if (cmp_en) begin
            check("R1", int'(valid_o), int'(m_valid), "valid_o vs model");
            check("R5", int'(per_cnt_o), m_per, "per_cnt_o vs model");
            check("R3", int'(hi_cnt_o), m_hi, "hi_cnt_o vs model");
            check("R10", int'(ovf_o), int'(m_ovf), "ovf_o vs model");
        end
    end

    int nvalid = 0, last_hi = 0, last_per = 0;
    always @(negedge clk) begin
        if (valid_o) begin
            nvalid++;
            last_hi = hi_cnt_o;
            last_per = per_cnt_o;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ref_i = 1'b0; fb_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R11", int'(valid_o), 0, "valid_o in reset");
        check("R11", int'(hi_cnt_o), 0, "hi_cnt_o in reset");
        check("R11", int'(per_cnt_o), 0, "per_cnt_o in reset");
        check("R11", int'(ovf_o), 0, "ovf_o in reset");
        rst = 1'b0;
        nvalid = 0;
    endtask

    task automatic run_wave(int p, int d, int n);
        for (int t = 0; t < n * p; t++) begin
            @(negedge clk);
            ref_i = (t % p) < (p / 2);
            fb_i  = ((((t - d) % p) + p) % p) < (p / 2);
        end
    endtask

    task automatic hold(bit r, bit f, int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ref_i = r; fb_i = f;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 200000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        cmp_en = 1;

        run_wave(40, 0, 3);
        check("R8", nvalid, 2, "strobes over 3 periods from reset");
        check("R2", last_hi, 0, "in-phase high count");
        check("R5", last_per, 40, "period length");

        run_wave(40, 3, 3);
        check("R3", last_hi, 6, "lag 3 high count");
        run_wave(40, -3, 3);
        check("R6", last_hi, 6, "lead 3 high count");
        run_wave(40, 20, 3);
        check("R4", last_hi, last_per, "antiphase high vs period");
        run_wave(40, 10, 3);
        check("R7", last_hi, 20, "quarter-turn high count");
        run_wave(24, 5, 3);
        check("R3", last_hi, 10, "lag 5 at period 24");
        check("R5", last_per, 24, "period 24 length");

        hold(1, 0, 10);
        hold(0, 1, 300);
        hold(1, 0, 10);
        hold(0, 1, 10);
        check("R10", int'(ovf_o), 1, "overflow flag");
        check("R10", last_per, MAX, "saturated period");
        check("R10", last_hi, MAX, "saturated high count");
        run_wave(40, 0, 2);
        check("R10", int'(ovf_o), 1, "overflow flag sticky");

        do_reset();
        check("R11", int'(ovf_o), 0, "overflow cleared by reset");
        run_wave(40, 10, 2);
        check("R8", nvalid, 1, "strobes over 2 periods after reset");
        hold(0, 0, 10);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule